// File: doc/BRIEF.md
# Staged Reset Sequencer

This block turns five independent reset requests into one internal system reset. Any request forces the reset on at once. The release waits for a fixed chain of stages. The oscillator stage waits a minimum number of cycles and needs the oscillator-ready status. The flash power stage enables flash power and waits a programmable settling time. The flash start stage sends a one-cycle start pulse and waits a fixed initialization count. A final wait holds until the flash reports ready. Reset drops only after every stage is complete and no request is present, so the processor starts from a fully initialized system.

A sticky cause register shows which requests caused the latest reset. A power-on request clears the earlier history. Software clears bits with a write-one-to-clear strobe. Every wait length is a parameter, given in clock cycles.

Top module: `rstseq_top`

## Requirements
- R1: Any of the five requests (power-on, external pin, watchdog, brown-out, software) drives `sys_rst` high in the same cycle, without waiting for a clock edge.
- R2: While any request is held, the sequence stays at its first stage. All release timing counts from the first rising edge at which no request is present, so a long external pin assertion delays the release.
- R3: The oscillator stage lasts OSC_CYC edges. It also lasts until one edge after `osc_ok` is seen high, whichever is later. `flash_pwr_en` rises at the edge that ends this stage.
- R4: `flash_pwr_en` stays high for PWR_CYC edges. Then `flash_init_go` is high for exactly one cycle.
- R5: INIT_CYC edges after the start pulse, `flash_ok` is sampled. `sys_rst` falls at the first later edge that sees `flash_ok` high. With both ready inputs high, this is edge OSC_CYC+PWR_CYC+INIT_CYC+1 after the requests clear.
- R6: A request that arrives during the sequence restarts it from the oscillator stage. `flash_pwr_en` drops at the next edge, and the full timing of R3 to R5 applies again.
- R7: `cause` is sticky. Bit 0 is power-on, bit 1 is external pin, bit 2 is watchdog, bit 3 is brown-out and bit 4 is software. Each bit is set at the edge after its request. A power-on request replaces the whole register with the requests present at that edge.
- R8: Bits written as 1 on `cause_clr` clear at the next edge. A request arriving in the same cycle wins over the clear.
- R9: A software request that lasts only one cycle still runs the complete sequence and is recorded.
- R10: `sys_rst` falls only on a clock edge. After release, `sys_rst` stays low and `flash_pwr_en` stays high until the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on reset request, active high |
| pin_req | input | 1 | External reset pin, already synchronized, active high |
| wdt_req | input | 1 | Watchdog reset request |
| bod_req | input | 1 | Brown-out reset request |
| sw_req | input | 1 | Software reset request, may be a one-cycle pulse |
| osc_ok | input | 1 | Oscillator reports stable clock |
| flash_ok | input | 1 | Flash reports initialization done |
| cause_clr | input | 5 | Write-one-to-clear strobe for `cause` |
| sys_rst | output | 1 | Internal system reset, active high |
| flash_pwr_en | output | 1 | Flash power enable |
| flash_init_go | output | 1 | One-cycle flash initialization start |
| cause | output | 5 | Sticky reset cause bits |

## Verification
A wrong stage or counter value shows up within one sequence as a shift in one of three edges: the rise of `flash_pwr_en`, the position of `flash_init_go`, or the fall of `sys_rst`. Each of these is measured as an exact edge count from the last request. Random delays on the two ready inputs show whether each stage waits for its own status and not for the other one. A lost restart shows as `flash_pwr_en` still high one edge after a mid-sequence request. A wrong cause update appears one edge after the request or clear strobe.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int NSRC = 5;
  localparam int SRC_POR = 0;
  localparam int SRC_PIN = 1;
  localparam int SRC_WDT = 2;
  localparam int SRC_BOD = 3;
  localparam int SRC_SW  = 4;

  typedef enum logic [2:0] {
    ST_OSC  = 3'd0,
    ST_PWR  = 3'd1,
    ST_INIT = 3'd2,
    ST_WAIT = 3'd3,
    ST_RUN  = 3'd4
  } seq_st_e;
endpackage

// File: rtl/rstseq_merge.sv
module rstseq_merge
  import rstseq_pkg::*;
(
  input  logic            por_req,
  input  logic            pin_req,
  input  logic            wdt_req,
  input  logic            bod_req,
  input  logic            sw_req,
  output logic [NSRC-1:0] req_vec,
  output logic            any_req
);
  always_comb begin
    req_vec          = '0;
    req_vec[SRC_POR] = por_req;
    req_vec[SRC_PIN] = pin_req;
    req_vec[SRC_WDT] = wdt_req;
    req_vec[SRC_BOD] = bod_req;
    req_vec[SRC_SW]  = sw_req;
    any_req          = |req_vec;
  end
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
  import rstseq_pkg::*;
(
  input  logic            clk,
  input  logic            por_req,
  input  logic [NSRC-1:0] req_vec,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] cause
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (por_req)         cause[i] <= req_vec[i];
      else if (req_vec[i]) cause[i] <= 1'b1;
      else if (clr[i])     cause[i] <= 1'b0;
    end
  end

  // R7: a power-on request always leaves its own bit set
  p_por_marks_r7: assert property (@(posedge clk) por_req |=> cause[SRC_POR]);
  // R8: a request beats a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (por_req)
    (req_vec[SRC_WDT] && clr[SRC_WDT]) |=> cause[SRC_WDT]);
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int OSC_CYC  = 72,
  parameter int PWR_CYC  = 1200,
  parameter int INIT_CYC = 250
) (
  input  logic clk,
  input  logic any_req,
  input  logic osc_ok,
  input  logic flash_ok,
  output logic rst_q,
  output logic pwr_q,
  output logic go_q
);
  localparam int MAXC = (OSC_CYC > PWR_CYC) ?
                        ((OSC_CYC > INIT_CYC) ? OSC_CYC : INIT_CYC) :
                        ((PWR_CYC > INIT_CYC) ? PWR_CYC : INIT_CYC);
  localparam int CW = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] OSC_LAST  = CW'(OSC_CYC - 1);
  localparam logic [CW-1:0] PWR_LAST  = CW'(PWR_CYC - 1);
  localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYC - 1);

  seq_st_e       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    go_q <= 1'b0;
    if (any_req) begin
      st    <= ST_OSC;
      cnt   <= '0;
      rst_q <= 1'b1;
      pwr_q <= 1'b0;
    end else begin
      case (st)
        ST_OSC: begin
          if (cnt == OSC_LAST) begin
            if (osc_ok) begin
              st    <= ST_PWR;
              cnt   <= '0;
              pwr_q <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PWR: begin
          if (cnt == PWR_LAST) begin
            st   <= ST_INIT;
            cnt  <= '0;
            go_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_INIT: begin
          if (cnt == INIT_LAST) begin
            st  <= ST_WAIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (flash_ok) begin
            st    <= ST_RUN;
            rst_q <= 1'b0;
          end
        end
        ST_RUN: ;
        default: begin
          st  <= ST_OSC;
          cnt <= '0;
        end
      endcase
    end
  end

  // R6: a request always restarts from the oscillator stage
  p_restart_r6: assert property (@(posedge clk)
    any_req |=> (st == ST_OSC && cnt == '0 && !pwr_q));
  // R3: without a ready oscillator the first stage is not left
  p_osc_gate_r3: assert property (@(posedge clk) disable iff (any_req)
    (st == ST_OSC && !osc_ok) |=> (st == ST_OSC));
  // R4: the start pulse is one cycle and only with flash power on
  p_go_single_r4: assert property (@(posedge clk) disable iff (any_req)
    go_q |=> !go_q);
  p_go_pwr_r4: assert property (@(posedge clk) disable iff (any_req)
    go_q |-> pwr_q);
  // R5: release only after the flash reported ready
  p_rel_flash_r5: assert property (@(posedge clk) disable iff (any_req)
    $fell(rst_q) |-> $past(flash_ok));
  // R10: after release the block stays released until a request
  p_run_stable_r10: assert property (@(posedge clk) disable iff (any_req)
    (st == ST_RUN) |=> (!rst_q && pwr_q));
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int OSC_CYC  = 72,
  parameter int PWR_CYC  = 1200,
  parameter int INIT_CYC = 250
) (
  input  logic            clk,
  input  logic            por_req,
  input  logic            pin_req,
  input  logic            wdt_req,
  input  logic            bod_req,
  input  logic            sw_req,
  input  logic            osc_ok,
  input  logic            flash_ok,
  input  logic [NSRC-1:0] cause_clr,
  output logic            sys_rst,
  output logic            flash_pwr_en,
  output logic            flash_init_go,
  output logic [NSRC-1:0] cause
);
  logic [NSRC-1:0] req_vec;
  logic            any_req;
  logic            rst_q;

  rstseq_merge u_merge (
    .por_req (por_req),
    .pin_req (pin_req),
    .wdt_req (wdt_req),
    .bod_req (bod_req),
    .sw_req  (sw_req),
    .req_vec (req_vec),
    .any_req (any_req)
  );

  rstseq_cause u_cause (
    .clk     (clk),
    .por_req (por_req),
    .req_vec (req_vec),
    .clr     (cause_clr),
    .cause   (cause)
  );

  rstseq_fsm #(
    .OSC_CYC  (OSC_CYC),
    .PWR_CYC  (PWR_CYC),
    .INIT_CYC (INIT_CYC)
  ) u_fsm (
    .clk      (clk),
    .any_req  (any_req),
    .osc_ok   (osc_ok),
    .flash_ok (flash_ok),
    .rst_q    (rst_q),
    .pwr_q    (flash_pwr_en),
    .go_q     (flash_init_go)
  );

  // Asynchronous assertion through the request path, clocked release.
  assign sys_rst = rst_q | any_req;

  // R10: reset only falls at a clock edge
  p_sync_fall_r10: assert property (@(posedge clk) disable iff (por_req)
    (!any_req && $past(sys_rst) && !sys_rst) |-> $past(rst_q));
endmodule

// File: tb/tb_rstseq_top.sv
module tb_rstseq_top;
  localparam int CLK_P = 10;
  localparam int OSC  = 6;
  localparam int PWR  = 15;
  localparam int INIT = 9;
  localparam int TOTAL = OSC + PWR + INIT + 1;

  logic clk = 1'b0;
  logic por_req = 1'b1, pin_req = 1'b0, wdt_req = 1'b0, bod_req = 1'b0, sw_req = 1'b0;
  logic osc_ok = 1'b1, flash_ok = 1'b1;
  logic [4:0] cause_clr = '0;
  logic sys_rst, flash_pwr_en, flash_init_go;
  logic [4:0] cause;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  rstseq_top #(.OSC_CYC(OSC), .PWR_CYC(PWR), .INIT_CYC(INIT)) dut (
    .clk(clk), .por_req(por_req), .pin_req(pin_req), .wdt_req(wdt_req),
    .bod_req(bod_req), .sw_req(sw_req), .osc_ok(osc_ok), .flash_ok(flash_ok),
    .cause_clr(cause_clr), .sys_rst(sys_rst), .flash_pwr_en(flash_pwr_en),
    .flash_init_go(flash_init_go), .cause(cause)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pwr(input int d);
    if (d == 0) return OSC;
    return (d + 1 > OSC) ? d + 1 : OSC;
  endfunction

  function automatic int exp_rel(input int go, input int f);
    int base = go + INIT + 1;
    if (f == 0) return base;
    return (f + 1 > base) ? f + 1 : base;
  endfunction

  // Requests are dropped before the call; edges are counted from there.
  task automatic measure(input int d, input int f,
                         output int pwr_at, output int go_at, output int go_n, output int rel_at);
    pwr_at = 0; go_at = 0; go_n = 0; rel_at = 0;
    for (int i = 1; i < 3000; i++) begin
      @(posedge clk); @(negedge clk);
      if (flash_pwr_en && pwr_at == 0) pwr_at = i;
      if (flash_init_go) begin
        go_n++;
        if (go_at == 0) go_at = i;
      end
      if (!sys_rst) begin rel_at = i; break; end
      if (i == d) osc_ok = 1'b1;
      if (i == f) flash_ok = 1'b1;
    end
  endtask

  task automatic drop_all();
    pin_req = 0; wdt_req = 0; bod_req = 0; sw_req = 0; por_req = 0;
  endtask

  task automatic full_check(input string tag);
    int p, g, gn, r;
    measure(0, 0, p, g, gn, r);
    check({tag, " R3 pwr edge"}, p, OSC);
    check({tag, " R4 go edge"}, g, OSC + PWR);
    check({tag, " R4 go width"}, gn, 1);
    check({tag, " R5 release edge"}, r, TOTAL);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p, g, gn, r, d, f, len;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // Reset state while power-on request is held
    check("R1 por holds sys_rst", sys_rst, 1);
    check("R2 pwr low during request", flash_pwr_en, 0);
    check("R4 go low during request", flash_init_go, 0);
    check("R7 cause after por", cause, 5'b00001);
    drop_all();
    full_check("por");
    repeat (4) @(negedge clk);
    check("R10 stays released", sys_rst, 0);
    check("R10 pwr stays on", flash_pwr_en, 1);

    // Each hardware source, held for a random length
    for (int s = 1; s <= 3; s++) begin
      cause_clr = 5'h1f;
      @(negedge clk);
      cause_clr = '0;
      check("R8 clear all", cause, 0);
      len = 1 + int'($urandom_range(0, 6));
      case (s)
        1: pin_req = 1;
        2: wdt_req = 1;
        default: bod_req = 1;
      endcase
      #1;
      check("R1 immediate assert", sys_rst, 1);
      repeat (len) @(negedge clk);
      check("R2 pwr off while held", flash_pwr_en, 0);
      check("R7 cause bit", cause, 1 << s);
      drop_all();
      full_check("R2 source");
    end

    // One-cycle software pulse
    @(negedge clk);
    sw_req = 1;
    #1;
    check("R9 sw asserts", sys_rst, 1);
    @(negedge clk);
    sw_req = 0;
    check("R9 sw cause", cause[4], 1);
    full_check("R9 sw");

    // Random ready delays
    for (int k = 0; k < 10; k++) begin
      d = int'($urandom_range(0, OSC + 8));
      f = int'($urandom_range(0, TOTAL + 10));
      @(negedge clk);
      wdt_req = 1;
      osc_ok = (d == 0);
      flash_ok = (f == 0);
      @(negedge clk);
      drop_all();
      measure(d, f, p, g, gn, r);
      check("R3 random pwr edge", p, exp_pwr(d));
      check("R4 random go edge", g, exp_pwr(d) + PWR);
      check("R5 random release", r, exp_rel(exp_pwr(d) + PWR, f));
      osc_ok = 1; flash_ok = 1;
    end

    // Restart in the middle of flash power-up
    @(negedge clk);
    pin_req = 1;
    @(negedge clk);
    drop_all();
    repeat (OSC + 3) @(negedge clk);
    check("R6 pwr on before restart", flash_pwr_en, 1);
    bod_req = 1;
    #1;
    check("R6 restart asserts", sys_rst, 1);
    @(negedge clk);
    drop_all();
    check("R6 pwr dropped", flash_pwr_en, 0);
    full_check("R6 restart");

    // Clear and set in the same cycle, then stickiness
    @(negedge clk);
    cause_clr = 5'h1f;
    wdt_req = 1;
    @(negedge clk);
    cause_clr = '0;
    drop_all();
    check("R8 set wins over clear", cause, 5'b00100);
    full_check("R8 seq");
    check("R7 sticky after release", cause, 5'b00100);

    // Power-on wipes history
    @(negedge clk);
    por_req = 1;
    @(negedge clk);
    drop_all();
    check("R7 por replaces cause", cause, 5'b00001);
    full_check("R7 por");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule